// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This unit decides, every clock cycle, how the fetch stage of a five-stage in-order pipeline (IF, ID, EX, MEM, WB) advances around conditional branches and exceptions. It follows every branch as it moves down the stages with a per-stage marker. From that marker and the resolution inputs it drives the program-counter select, a fetch stall, and one kill bit for each of the four youngest stages. It also keeps a running count of the fetch slots lost to bubbles and flushes, so the penalty of each configuration can be measured.

Two configuration codes are captured while reset is asserted. The first picks the hazard policy: hold fetch until the branch resolves, keep fetching sequentially and flush on a taken branch, or honour one delay slot. The second picks the stage in which branches resolve, which sets the taken-branch penalty to three, two or one slots. An exception flagged in MEM overrides all of this. It redirects fetch to a fixed handler address and squashes the faulting instruction together with everything younger.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: `cfg_policy` (0 = stall, 1 = flush, 2 = delay slot, 3 behaves as 1) and `cfg_resolve` are captured only in cycles where `rst` is high. Changes made after reset has been released have no effect until the next reset.
- R2: In stall policy, `stall_fetch` is 1 and the IF valid bit is 0 in every cycle in which a branch occupies a stage from ID through the resolve stage. `pc_sel` is 1 (hold) in those cycles unless a redirect is in progress, so every branch costs exactly D lost slots, where D is the resolve depth.
- R3: The resolve depth D (IF = stage 0) is 3 (MEM) for `cfg_resolve` 0 or 3, 2 (EX) for code 1, and 1 (ID) for code 2. Resolution is taken from `res_valid` in the cycle in which the branch occupies stage D.
- R4: In flush or stall policy, a taken resolution sets `stage_kill` bits 0 through D-1 (bit i = stage i) and `pc_sel` to 2 (target) with `pc_target` = `res_target`. `ifid_flush` equals `stage_kill[0]`, and a flushed taken branch loses D slots.
- R5: In flush policy, a not-taken branch keeps `pc_sel` at 0 (sequential), kills nothing, and adds nothing to `lost_slots`.
- R6: In delay-slot policy, a taken branch kills only stages 0 through D-2, which keeps the instruction in stage D-1 alive, and still selects the target. The loss is D-1 slots.
- R7: `exc_valid` while MEM (stage 3) holds a valid instruction sets all four kill bits and selects the target with `pc_target` equal to parameter HANDLER (default 32'h80). It takes priority over any branch resolution.
- R8: A redirect in the same cycle as a fetch stall drives `pc_sel` to 2 (target), not 1 (hold).
- R9: A stage whose kill bit is set in a cycle has its downstream valid bit cleared in the next cycle. The stage's valid bit i+1 reads 0.
- R10: `res_valid` is ignored when no branch occupies stage D: no kill, and `pc_sel` stays sequential.
- R11: `lost_slots` grows each cycle by one for a stalled fetch plus one for each valid instruction that is killed. It is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the configuration capture window |
| cfg_policy | input | 2 | Hazard policy code |
| cfg_resolve | input | 2 | Resolve stage code |
| if_is_branch | input | 1 | Instruction fetched this cycle is a conditional branch |
| res_valid | input | 1 | Branch outcome presented by the resolve stage |
| res_taken | input | 1 | Branch condition is true |
| res_target | input | AW | Branch target address |
| exc_valid | input | 1 | Exception raised by the instruction in MEM |
| pc_sel | output | 2 | 0 sequential, 1 hold, 2 target |
| pc_target | output | AW | Address loaded when `pc_sel` is 2 |
| stall_fetch | output | 1 | Fetch suppressed; IF slot is a bubble |
| ifid_flush | output | 1 | Invalidate the IF/ID register at the next edge |
| stage_kill | output | 4 | Per-stage squash, bit 0 = IF to bit 3 = MEM |
| stage_valid | output | 5 | Per-stage valid, bit 0 = IF to bit 4 = WB |
| lost_slots | output | CW | Count of bubbles and flushed slots |

## Verification
Several properties are checked continuously. A hold select only happens together with a stall, and a killed stage comes up invalid one cycle later. Any kill forces the target select, an exception in MEM always yields a full flush to the handler, and sequential cycles leave the loss count unchanged. Other behaviour only shows up as the outcome of a whole branch, so the directed scenarios must show it: the exact penalty per policy and resolve depth, the survival of the delay-slot instruction, the rejection of configuration changes made outside reset, and the rejection of a resolution that arrives when no branch is in the resolve stage.

// File: rtl/bhz_pkg.sv
`timescale 1ns/1ps
package bhz_pkg;

    localparam int NSTAGE    = 5;
    localparam int NKILL     = NSTAGE - 1;
    localparam int EXC_STAGE = 3;

    typedef enum logic [1:0] {
        POL_STALL = 2'd0,
        POL_FLUSH = 2'd1,
        POL_SLOT  = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        PCS_SEQ    = 2'd0,
        PCS_HOLD   = 2'd1,
        PCS_TARGET = 2'd2
    } pcsel_e;

    typedef struct packed {
        policy_e    policy;
        logic [1:0] depth;
    } cfg_t;

    function automatic policy_e decode_policy(input logic [1:0] code);
        case (code)
            2'd0:    return POL_STALL;
            2'd2:    return POL_SLOT;
            default: return POL_FLUSH;
        endcase
    endfunction

    function automatic logic [1:0] decode_depth(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd2;
            2'd2:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [NKILL-1:0] below(input logic [1:0] n);
        logic [NKILL-1:0] m;
        for (int i = 0; i < NKILL; i++)
            m[i] = (i < int'(n));
        return m;
    endfunction

endpackage

// File: rtl/bhz_cfg_latch.sv
`timescale 1ns/1ps
module bhz_cfg_latch
    import bhz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pol_code,
    input  logic [1:0] res_code,
    output cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.policy <= decode_policy(pol_code);
            cfg.depth  <= decode_depth(res_code);
        end
    end
endmodule

// File: rtl/bhz_stage_track.sv
`timescale 1ns/1ps
module bhz_stage_track
    import bhz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             if_live,
    input  logic             if_branch,
    input  logic [NKILL-1:0] kill,
    output logic [NSTAGE-1:1] valid_q,
    output logic [NKILL-1:1]  br_q
);
    logic [NSTAGE-1:0] v_all;
    logic [NKILL-1:0]  b_all;

    assign v_all = {valid_q, if_live};
    assign b_all = {br_q, if_branch & if_live};

    for (genvar i = 1; i < NSTAGE; i++) begin : g_valid
        always_ff @(posedge clk) begin
            if (rst) valid_q[i] <= 1'b0;
            else     valid_q[i] <= v_all[i-1] & ~kill[i-1];
        end
    end

    for (genvar i = 1; i < NKILL; i++) begin : g_br
        always_ff @(posedge clk) begin
            if (rst) br_q[i] <= 1'b0;
            else     br_q[i] <= b_all[i-1] & ~kill[i-1];
        end
    end
endmodule

// File: rtl/bhz_redirect.sv
`timescale 1ns/1ps
module bhz_redirect
    import bhz_pkg::*;
#(
    parameter int              AW      = 32,
    parameter logic [AW-1:0]   HANDLER = AW'(32'h80)
) (
    input  cfg_t              cfg,
    input  logic [NKILL-1:1]  br_q,
    input  logic              mem_valid,
    input  logic              res_valid,
    input  logic              res_taken,
    input  logic [AW-1:0]     res_target,
    input  logic              exc_valid,
    output logic              waiting,
    output pcsel_e            sel,
    output logic [AW-1:0]     target,
    output logic [NKILL-1:0]  kill
);
    logic [NKILL-1:1] span;
    logic             at_resolve;
    logic             exc_hit;
    logic             taken_hit;

    always_comb begin
        for (int i = 1; i < NKILL; i++)
            span[i] = (i <= int'(cfg.depth));
        at_resolve = br_q[cfg.depth];
        waiting    = (cfg.policy == POL_STALL) && |(br_q & span);
        exc_hit    = exc_valid && mem_valid;
        taken_hit  = res_valid && res_taken && at_resolve;

        kill   = '0;
        target = res_target;
        if (exc_hit) begin
            kill   = '1;
            target = HANDLER;
        end else if (taken_hit) begin
            kill = (cfg.policy == POL_SLOT) ? below(cfg.depth - 2'd1)
                                            : below(cfg.depth);
        end

        if (exc_hit || taken_hit) sel = PCS_TARGET;
        else if (waiting)         sel = PCS_HOLD;
        else                      sel = PCS_SEQ;
    end
endmodule

// File: rtl/bhz_penalty_ctr.sv
`timescale 1ns/1ps
module bhz_penalty_ctr
    import bhz_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic [NKILL-1:0] kill,
    input  logic [NKILL-1:0] live,
    output logic [CW-1:0]    count
);
    localparam int IW = $clog2(NKILL + 2);
    logic [IW-1:0] inc;

    always_comb begin
        inc = IW'(stall);
        for (int i = 0; i < NKILL; i++)
            inc = inc + IW'(kill[i] & live[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + CW'(inc);
    end
endmodule

// File: rtl/branch_hazard_ctrl.sv
`timescale 1ns/1ps
module branch_hazard_ctrl
    import bhz_pkg::*;
#(
    parameter int            AW      = 32,
    parameter int            CW      = 16,
    parameter logic [AW-1:0] HANDLER = AW'(32'h80)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_policy,
    input  logic [1:0]    cfg_resolve,
    input  logic          if_is_branch,
    input  logic          res_valid,
    input  logic          res_taken,
    input  logic [AW-1:0] res_target,
    input  logic          exc_valid,
    output logic [1:0]    pc_sel,
    output logic [AW-1:0] pc_target,
    output logic          stall_fetch,
    output logic          ifid_flush,
    output logic [3:0]    stage_kill,
    output logic [4:0]    stage_valid,
    output logic [CW-1:0] lost_slots
);
    cfg_t               cfg;
    logic [NSTAGE-1:1]  valid_q;
    logic [NKILL-1:1]   br_q;
    logic               waiting;
    pcsel_e             sel;
    logic [NKILL-1:0]   kill;

    bhz_cfg_latch u_cfg (
        .clk(clk), .rst(rst),
        .pol_code(cfg_policy), .res_code(cfg_resolve),
        .cfg(cfg)
    );

    bhz_redirect #(.AW(AW), .HANDLER(HANDLER)) u_redir (
        .cfg(cfg), .br_q(br_q), .mem_valid(valid_q[EXC_STAGE]),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .exc_valid(exc_valid),
        .waiting(waiting), .sel(sel), .target(pc_target), .kill(kill)
    );

    bhz_stage_track u_track (
        .clk(clk), .rst(rst),
        .if_live(~waiting), .if_branch(if_is_branch),
        .kill(kill), .valid_q(valid_q), .br_q(br_q)
    );

    bhz_penalty_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst),
        .stall(waiting), .kill(kill), .live(stage_valid[NKILL-1:0]),
        .count(lost_slots)
    );

    assign stage_valid = {valid_q, ~waiting};
    assign stall_fetch = waiting;
    assign stage_kill  = kill;
    assign ifid_flush  = kill[0];
    assign pc_sel      = sel;
endmodule

// File: rtl/branch_hazard_ctrl_chk.sv
`timescale 1ns/1ps
module branch_hazard_ctrl_chk #(
    parameter int            AW      = 32,
    parameter int            CW      = 16,
    parameter logic [AW-1:0] HANDLER = AW'(32'h80)
) (
    input logic          clk,
    input logic          rst,
    input logic          exc_valid,
    input logic [1:0]    pc_sel,
    input logic [AW-1:0] pc_target,
    input logic          stall_fetch,
    input logic [3:0]    stage_kill,
    input logic [4:0]    stage_valid,
    input logic [CW-1:0] lost_slots
);
    a_r2_hold_needs_stall: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == 2'd1) |-> stall_fetch);

    a_r2_stall_leaves_bubble: assert property (@(posedge clk) disable iff (rst)
        stall_fetch |=> !stage_valid[1]);

    a_r4_kill_selects_target: assert property (@(posedge clk) disable iff (rst)
        (|stage_kill) |-> (pc_sel == 2'd2));

    a_r4_sel_legal: assert property (@(posedge clk) disable iff (rst)
        pc_sel != 2'd3);

    a_r7_exc_full_flush: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && stage_valid[3]) |->
            (stage_kill == 4'hF && pc_sel == 2'd2 && pc_target == HANDLER));

    a_r9_killed_cleared: assert property (@(posedge clk) disable iff (rst)
        (|stage_kill) |=> ((stage_valid[4:1] & $past(stage_kill)) == 4'h0));

    a_r11_no_loss_on_seq: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == 2'd0 && !stall_fetch) |=> $stable(lost_slots));
endmodule

bind branch_hazard_ctrl branch_hazard_ctrl_chk #(.AW(AW), .CW(CW), .HANDLER(HANDLER)) u_chk (
    .clk(clk), .rst(rst), .exc_valid(exc_valid),
    .pc_sel(pc_sel), .pc_target(pc_target), .stall_fetch(stall_fetch),
    .stage_kill(stage_kill), .stage_valid(stage_valid), .lost_slots(lost_slots)
);

// File: tb/tb_branch_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_branch_hazard_ctrl;
    localparam int          AW  = 32;
    localparam int          CW  = 16;
    localparam logic [31:0] HVEC = 32'h80;
    localparam logic [31:0] TGT  = 32'h0000_1240;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    cfg_policy, cfg_resolve;
    logic          if_is_branch, res_valid, res_taken, exc_valid;
    logic [AW-1:0] res_target;
    logic [1:0]    pc_sel;
    logic [AW-1:0] pc_target;
    logic          stall_fetch, ifid_flush;
    logic [3:0]    stage_kill;
    logic [4:0]    stage_valid;
    logic [CW-1:0] lost_slots;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    branch_hazard_ctrl dut (
        .clk(clk), .rst(rst), .cfg_policy(cfg_policy), .cfg_resolve(cfg_resolve),
        .if_is_branch(if_is_branch), .res_valid(res_valid), .res_taken(res_taken),
        .res_target(res_target), .exc_valid(exc_valid),
        .pc_sel(pc_sel), .pc_target(pc_target), .stall_fetch(stall_fetch),
        .ifid_flush(ifid_flush), .stage_kill(stage_kill), .stage_valid(stage_valid),
        .lost_slots(lost_slots)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] pol, input logic [1:0] resc);
        @(negedge clk);
        rst = 1'b1; cfg_policy = pol; cfg_resolve = resc;
        if_is_branch = 0; res_valid = 0; res_taken = 0; exc_valid = 0;
        res_target = TGT;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(2'd1, 2'd0);
        rst = 1'b1;
        #1;
        chk("R11 count zero in reset", lost_slots, 0);
        chk("R9 stages empty in reset", stage_valid, 5'b00001);
        chk("R5 sequential in reset", pc_sel, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Full branch scenario: fetch branch, resolve at depth d, inspect outcome.
    task automatic t_branch(input string tag, input logic [1:0] pol, input logic [1:0] resc,
                            input int d, input bit tk, input logic [3:0] exp_kill,
                            input logic [2:0] exp_vmask, input int exp_loss);
        logic [CW-1:0] c0;
        do_reset(pol, resc);
        repeat (5) @(negedge clk);
        if_is_branch = 1'b1;
        #1;
        c0 = lost_slots;
        chk({tag, " no stall at branch fetch"}, stall_fetch, 0);
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            if_is_branch = 1'b0;
            if (k == d) begin
                res_valid = 1'b1; res_taken = tk; res_target = TGT;
            end
            #1;
            chk({tag, " R2 stall while branch in flight"}, stall_fetch, (pol == 2'd0));
            if (k == d) begin
                chk({tag, " pc_sel at resolve"}, pc_sel,
                    tk ? 2 : ((pol == 2'd0) ? 1 : 0));
                chk({tag, " kill mask"}, stage_kill, exp_kill);
                chk({tag, " R4 ifid_flush"}, ifid_flush, exp_kill[0]);
                if (tk) chk({tag, " target"}, pc_target, TGT);
            end
        end
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b0;
        #1;
        chk({tag, " R9 valid after resolve"},
            (stage_valid >> 1) & ((1 << d) - 1), exp_vmask);
        chk({tag, " R11 lost slots"}, lost_slots - c0, exp_loss);
        chk({tag, " fetch resumes"}, stall_fetch, 0);
    endtask

    task automatic t_exception;
        logic [CW-1:0] c0;
        do_reset(2'd1, 2'd0);
        repeat (5) @(negedge clk);
        #1; c0 = lost_slots;
        @(negedge clk);
        exc_valid = 1'b1; res_valid = 1'b1; res_taken = 1'b1;
        #1;
        chk("R7 exception kills all", stage_kill, 4'hF);
        chk("R7 exception selects target", pc_sel, 2);
        chk("R7 handler address", pc_target, HVEC);
        @(negedge clk);
        exc_valid = 1'b0; res_valid = 1'b0; res_taken = 1'b0;
        #1;
        chk("R9 stages cleared after exception", stage_valid[4:1], 4'h0);
        chk("R11 exception loss", lost_slots - c0, 4);
    endtask

    task automatic t_stall_vs_redirect;
        do_reset(2'd0, 2'd0);
        repeat (5) @(negedge clk);
        if_is_branch = 1'b1;
        @(negedge clk);
        if_is_branch = 1'b0; exc_valid = 1'b1;
        #1;
        chk("R8 stall cycle still stalls", stall_fetch, 1);
        chk("R8 redirect beats hold", pc_sel, 2);
        chk("R8 redirect to handler", pc_target, HVEC);
        @(negedge clk);
        exc_valid = 1'b0;
        #1;
        chk("R8 branch squashed, fetch resumes", stall_fetch, 0);
    endtask

    task automatic t_cfg_ignored;
        do_reset(2'd1, 2'd0);
        repeat (5) @(negedge clk);
        cfg_policy = 2'd0; cfg_resolve = 2'd2;
        if_is_branch = 1'b1;
        @(negedge clk);
        if_is_branch = 1'b0;
        res_valid = 1'b1; res_taken = 1'b1;
        #1;
        chk("R1 policy change ignored", stall_fetch, 0);
        chk("R1 resolve change ignored", pc_sel, 0);
        res_valid = 1'b0; res_taken = 1'b0;
        @(negedge clk);
        @(negedge clk);
        res_valid = 1'b1; res_taken = 1'b1;
        #1;
        chk("R1 original depth still used", pc_sel, 2);
        chk("R1 original policy kill", stage_kill, 4'b0111);
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b0;
    endtask

    task automatic t_spurious_resolve;
        do_reset(2'd1, 2'd1);
        repeat (5) @(negedge clk);
        res_valid = 1'b1; res_taken = 1'b1;
        #1;
        chk("R10 no branch, no kill", stage_kill, 0);
        chk("R10 no branch, sequential", pc_sel, 0);
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b0;
        #1;
        chk("R10 pipeline intact", stage_valid, 5'b11111);
    endtask

    initial begin
        rst = 1'b1;
        t_reset_state();
        t_branch("R2 stall d3 taken",     2'd0, 2'd0, 3, 1, 4'b0111, 3'b000, 3);
        t_branch("R2 stall d3 not taken", 2'd0, 2'd0, 3, 0, 4'b0000, 3'b000, 3);
        t_branch("R3 stall d1 taken",     2'd0, 2'd2, 1, 1, 4'b0001, 3'b000, 1);
        t_branch("R4 flush d3 taken",     2'd1, 2'd0, 3, 1, 4'b0111, 3'b000, 3);
        t_branch("R5 flush d3 not taken", 2'd1, 2'd0, 3, 0, 4'b0000, 3'b111, 0);
        t_branch("R3 flush d2 taken",     2'd1, 2'd1, 2, 1, 4'b0011, 3'b000, 2);
        t_branch("R3 flush d1 taken",     2'd3, 2'd2, 1, 1, 4'b0001, 3'b000, 1);
        t_branch("R6 slot d3 taken",      2'd2, 2'd3, 3, 1, 4'b0011, 3'b100, 2);
        t_branch("R6 slot d1 taken",      2'd2, 2'd2, 1, 1, 4'b0000, 3'b001, 0);
        t_branch("R6 slot d2 not taken",  2'd2, 2'd1, 2, 0, 4'b0000, 3'b011, 0);
        t_exception();
        t_stall_vs_redirect();
        t_cfg_ignored();
        t_spurious_resolve();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule